// File: doc/BRIEF.md
# Dual-phase serial audio transmitter

This block is the transmit half of a synchronous serial audio port. Parallel words enter a one-word holding register through a valid/ready handshake. They leave on a single data line, most significant bit first, one bit for each pulse of a bit-clock enable. Frame timing comes from an external frame sync that is sampled on those same enable pulses. Both the bit-clock enable and the frame sync are produced by a separate generator.

A frame is built from one phase or two. Each phase has its own word size and its own word count. The first data bit either shares the sync slot or follows it after one empty slot. A 32-bit word size lets two packed 16-bit stereo samples travel as a single element, so an underrun repeats the whole pair. When no word is waiting at the start of a word slot, the previous word is sent again and a sticky underrun flag is raised. A frame sync that arrives before the current frame has finished is either ignored or, depending on a control bit, treated as a sync error that restarts the frame.

Top module: `aud_tx`

## Requirements
- R1: While `run` is low, the transmitter is held idle. `sdo` reads 0 and `sync_err` reads 0 after the next clock edge, whatever the frame sync does.
- R2: The 3-bit word-size codes at `ctl[7:5]` (phase 1) and `ctl[23:21]` (phase 2) map as follows: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32. A word of N bits is taken from `in_data[N-1:0]` and sent from bit N-1 down to bit 0.
- R3: `ctl[14:8]` holds the phase-1 word count minus one. With `ctl[31]` clear, a frame ends after that many phase-1 words.
- R4: With `ctl[31]` set, phase 2 follows the last phase-1 word with no gap. Phase 2 uses its own size code and its own count, which `ctl[30:24]` holds as the word count minus one.
- R5: With `ctl[16]` clear, the first data bit is driven in the same bit slot as the accepted frame sync. With `ctl[16]` set, one slot of 0 comes first and the data starts in the next slot.
- R6: A frame sync counts as early if it arrives while a frame is in progress and is not on the slot that ends the frame's final bit. With `ctl[18]` clear, an early sync sets `sync_err` and restarts the frame. With `ctl[18]` set, an early sync has no effect on `sdo`.
- R7: Once set, `sync_err` stays high until `run` is brought low.
- R8: If the holding register is empty when a word slot begins, the previously sent word is sent again and `underrun` is set. `underrun` stays high until `underrun_clr` is applied; a new underrun on the same edge takes precedence over the clear.
- R9: `in_ready` is high exactly when the holding register is empty. A word is accepted on a clock edge with `in_valid` and `in_ready` both high. The register empties only when a word slot begins, which happens on a bit-clock-enable edge.
- R10: `sdo` is 0 in every bit slot outside the word slots, which covers the gap after a frame and the delay slot.
- R11: `sdo` changes only on clock edges where `bclk_en` is high, except when `run` is brought low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Transmitter release; low holds it idle and clears the sync error |
| bclk_en | input | 1 | One-cycle pulse marking each bit slot |
| fsync | input | 1 | Frame sync, sampled when `bclk_en` is high |
| ctl | input | 32 | Frame configuration (field positions as in R2 to R6) |
| in_data | input | 32 | Parallel word to transmit |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | Holding register is empty |
| underrun_clr | input | 1 | Clears the underrun flag |
| sdo | output | 1 | Serial data out |
| sync_err | output | 1 | Sticky early-frame-sync error |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default 32-bit word and 7-bit count fields, so every size code and dual-phase frames of mixed size can be reached. It varies the bit-clock divide ratio (2 and 3 system clocks per slot) and the frame sync period. Periods shorter than the frame expose the error and ignore paths. A period equal to the frame length, with zero delay, exercises the back-to-back frame boundary. Stopping the word source exercises the underrun repeat of a full 32-bit packed pair.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
    localparam int WORD_W = 32;
    localparam int FLEN_W = 7;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DELAY  = 2'd1,
        ST_ACTIVE = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [2:0]        wl1;
        logic [FLEN_W-1:0] fl1;
        logic [2:0]        wl2;
        logic [FLEN_W-1:0] fl2;
        logic              dual;
        logic              dly;
        logic              ign;
    } tx_cfg_t;

    // Size code to bit count; unused codes select the full word.
    function automatic logic [BIT_W:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return (BIT_W+1)'(8);
            3'd1:    return (BIT_W+1)'(12);
            3'd2:    return (BIT_W+1)'(16);
            3'd3:    return (BIT_W+1)'(20);
            3'd4:    return (BIT_W+1)'(24);
            default: return (BIT_W+1)'(WORD_W);
        endcase
    endfunction
endpackage

// File: rtl/aud_tx_hold.sv
module aud_tx_hold
    import aud_tx_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          take,
    output logic [DW-1:0] hold_data,
    output logic          hold_full
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end else if (in_valid && !hold_q.full) begin
            hold_d.data = in_data;
            hold_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign in_ready  = !hold_q.full;
    assign hold_data = hold_q.data;
    assign hold_full = hold_q.full;
endmodule

// File: rtl/aud_tx_frame.sv
module aud_tx_frame
    import aud_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bclk_en,
    input  logic              fsync,
    input  tx_cfg_t           cfg,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_data,
    output logic              take,
    output logic              ev_sync,
    output logic              ev_unr,
    output logic              sdo
);
    typedef struct packed {
        tx_state_e         st;
        logic              ph;
        logic [FLEN_W-1:0] widx;
        logic [BIT_W-1:0]  bi;
        logic [WORD_W-1:0] cur;
        logic              sdo;
    } frame_t;

    frame_t fr_d, fr_q;

    logic [BIT_W:0]    len1, len2, len_cur, load_len;
    logic [FLEN_W-1:0] fl_cur;
    logic              final_bit, early, start, load;

    always_comb begin
        fr_d     = fr_q;
        take     = 1'b0;
        ev_sync  = 1'b0;
        ev_unr   = 1'b0;
        load     = 1'b0;
        len1     = word_bits(cfg.wl1);
        len2     = word_bits(cfg.wl2);
        len_cur  = fr_q.ph ? len2 : len1;
        fl_cur   = fr_q.ph ? cfg.fl2 : cfg.fl1;
        load_len = len1;
        // The slot that ends the last bit of the frame may carry the next sync.
        final_bit = (fr_q.st == ST_ACTIVE) && (fr_q.bi == '0) &&
                    (fr_q.widx == fl_cur) && (fr_q.ph || !cfg.dual);
        early = fsync && (fr_q.st != ST_IDLE) && !final_bit;
        start = fsync && !(early && cfg.ign);

        if (!run) begin
            fr_d.st  = ST_IDLE;
            fr_d.sdo = 1'b0;
        end else if (bclk_en) begin
            if (start) begin
                ev_sync   = early;
                fr_d.ph   = 1'b0;
                fr_d.widx = '0;
                if (cfg.dly) begin
                    fr_d.st  = ST_DELAY;
                    fr_d.sdo = 1'b0;
                end else begin
                    fr_d.st  = ST_ACTIVE;
                    load     = 1'b1;
                end
            end else begin
                case (fr_q.st)
                    ST_IDLE: fr_d.sdo = 1'b0;
                    ST_DELAY: begin
                        fr_d.st = ST_ACTIVE;
                        load    = 1'b1;
                    end
                    ST_ACTIVE: begin
                        if (fr_q.bi != '0) begin
                            fr_d.bi  = fr_q.bi - 1'b1;
                            fr_d.sdo = fr_q.cur[fr_q.bi - 1'b1];
                        end else if (fr_q.widx != fl_cur) begin
                            fr_d.widx = fr_q.widx + 1'b1;
                            load      = 1'b1;
                            load_len  = len_cur;
                        end else if (!fr_q.ph && cfg.dual) begin
                            fr_d.ph   = 1'b1;
                            fr_d.widx = '0;
                            load      = 1'b1;
                            load_len  = len2;
                        end else begin
                            fr_d.st  = ST_IDLE;
                            fr_d.sdo = 1'b0;
                        end
                    end
                    default: begin
                        fr_d.st  = ST_IDLE;
                        fr_d.sdo = 1'b0;
                    end
                endcase
            end

            if (load) begin
                take     = hold_full;
                ev_unr   = !hold_full;
                fr_d.cur = hold_full ? hold_data : fr_q.cur;
                fr_d.bi  = BIT_W'(load_len - 1'b1);
                fr_d.sdo = fr_d.cur[fr_d.bi];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{st: ST_IDLE, default: '0};
        else        fr_q <= fr_d;
    end

    assign sdo = fr_q.sdo;
endmodule

// File: rtl/aud_tx_flags.sv
module aud_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ev_sync,
    input  logic ev_unr,
    input  logic underrun_clr,
    output logic sync_err,
    output logic underrun
);
    typedef struct packed {
        logic serr;
        logic unr;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (!run)         fl_d.serr = 1'b0;
        else if (ev_sync) fl_d.serr = 1'b1;
        if (ev_unr)            fl_d.unr = 1'b1;
        else if (underrun_clr) fl_d.unr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign sync_err = fl_q.serr;
    assign underrun = fl_q.unr;
endmodule

// File: rtl/aud_tx.sv
module aud_tx
    import aud_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bclk_en,
    input  logic              fsync,
    input  logic [31:0]       ctl,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              underrun_clr,
    output logic              sdo,
    output logic              sync_err,
    output logic              underrun
);
    tx_cfg_t           cfg;
    logic              take, ev_sync, ev_unr, hold_full;
    logic [WORD_W-1:0] hold_data;
    logic              unused_ctl;

    assign cfg.wl1  = ctl[7:5];
    assign cfg.fl1  = ctl[8 +: FLEN_W];
    assign cfg.dly  = ctl[16];
    assign cfg.ign  = ctl[18];
    assign cfg.wl2  = ctl[23:21];
    assign cfg.fl2  = ctl[24 +: FLEN_W];
    assign cfg.dual = ctl[31];
    assign unused_ctl = ^{ctl[4:0], ctl[15], ctl[17], ctl[20:19]};

    aud_tx_hold #(.DW(WORD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .take     (take),
        .hold_data(hold_data),
        .hold_full(hold_full)
    );

    aud_tx_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .bclk_en  (bclk_en),
        .fsync    (fsync),
        .cfg      (cfg),
        .hold_full(hold_full),
        .hold_data(hold_data),
        .take     (take),
        .ev_sync  (ev_sync),
        .ev_unr   (ev_unr),
        .sdo      (sdo)
    );

    aud_tx_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .ev_sync     (ev_sync),
        .ev_unr      (ev_unr),
        .underrun_clr(underrun_clr),
        .sync_err    (sync_err),
        .underrun    (underrun)
    );
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic bclk_en,
    input logic in_valid,
    input logic in_ready,
    input logic underrun_clr,
    input logic sdo,
    input logic sync_err,
    input logic underrun
);
    a_r1_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sdo && !sync_err));

    a_r11_sdo_on_bit_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bclk_en) |=> $stable(sdo));

    a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r9_drain_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !bclk_en) |=> !in_ready);

    a_r7_sync_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync_err) |=> sync_err);

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !underrun_clr) |=> underrun);
endmodule

bind aud_tx aud_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .bclk_en     (bclk_en),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .underrun_clr(underrun_clr),
    .sdo         (sdo),
    .sync_err    (sync_err),
    .underrun    (underrun)
);

// File: tb/sim_aud_tx.sv
module sim_aud_tx;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        bclk_en = 1'b0;
    logic        fsync = 1'b0;
    logic [31:0] ctl = '0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        underrun_clr = 1'b0;
    logic        in_ready, sdo, sync_err, underrun;

    int    n_cmp = 0, n_bad = 0, cyc = 0, slot = 0, wd = 0;
    int    div = 2, per = 80;
    bit    fs_on = 1'b0, feed_en = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int          m_st = 0, m_ph = 0, m_widx = 0, m_bi = 0, m_seq = 0;
    logic [31:0] m_cur = '0;
    logic [31:0] m_q[$];
    bit          m_sdo = 0, m_err = 0, m_unr = 0;

    aud_tx u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .bclk_en(bclk_en), .fsync(fsync),
        .ctl(ctl), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .underrun_clr(underrun_clr), .sdo(sdo), .sync_err(sync_err), .underrun(underrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] gen(int s);
        return (32'(s) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic int bits_of(logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] mk(int wl1, int fl1, int wl2, int fl2,
                                       bit dual, bit dly, bit ign);
        logic [31:0] c = '0;
        c[7:5] = 3'(wl1);   c[14:8] = 7'(fl1);
        c[23:21] = 3'(wl2); c[30:24] = 7'(fl2);
        c[31] = dual; c[16] = dly; c[18] = ign;
        return c;
    endfunction

    task automatic m_start_word(int nbits, bit full, ref bit took, ref bit unr);
        if (full) begin m_cur = m_q[0]; took = 1; end
        else unr = 1;
        m_bi  = nbits - 1;
        m_sdo = m_cur[m_bi];
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_widx = 0; m_bi = 0; m_cur = '0;
            m_sdo = 0; m_err = 0; m_unr = 0; m_q.delete();
        end else begin
            automatic bit full   = (m_q.size() != 0);
            automatic bit accept = in_valid && !full;
            automatic bit took = 0, ev_s = 0, ev_u = 0;
            automatic int fl1 = ctl[14:8], fl2 = ctl[30:24];
            automatic int l1 = bits_of(ctl[7:5]), l2 = bits_of(ctl[23:21]);
            automatic bit dual = ctl[31];
            automatic int fl = (m_ph == 1) ? fl2 : fl1;
            automatic int ln = (m_ph == 1) ? l2 : l1;
            if (!run) begin
                m_st = 0; m_sdo = 0;
            end else if (bclk_en) begin
                automatic bit fin = (m_st == 2) && (m_bi == 0) && (m_widx == fl)
                                    && ((m_ph == 1) || !dual);
                automatic bit erly = fsync && (m_st != 0) && !fin;
                if (fsync && !(erly && ctl[18])) begin
                    ev_s = erly; m_ph = 0; m_widx = 0;
                    if (ctl[16]) begin m_st = 1; m_sdo = 0; end
                    else begin m_st = 2; m_start_word(l1, full, took, ev_u); end
                end else if (m_st == 0) begin
                    m_sdo = 0;
                end else if (m_st == 1) begin
                    m_st = 2; m_start_word(l1, full, took, ev_u);
                end else if (m_bi > 0) begin
                    m_bi = m_bi - 1; m_sdo = m_cur[m_bi];
                end else if (m_widx != fl) begin
                    m_widx++; m_start_word(ln, full, took, ev_u);
                end else if (m_ph == 0 && dual) begin
                    m_ph = 1; m_widx = 0; m_start_word(l2, full, took, ev_u);
                end else begin
                    m_st = 0; m_sdo = 0;
                end
            end
            if (!run) m_err = 0; else if (ev_s) m_err = 1;
            if (ev_u) m_unr = 1; else if (underrun_clr) m_unr = 0;
            if (took) void'(m_q.pop_front());
            if (accept) begin m_q.push_back(in_data); m_seq++; end
        end
    end

    task automatic chk(string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    // compare away from the active edge, then drive the next stimulus
    always @(negedge clk) begin
        if (rst_n) begin
            chk("sdo", sdo, m_sdo);
            chk("in_ready", in_ready, m_q.size() == 0);
            chk("sync_err", sync_err, m_err);
            chk("underrun", underrun, m_unr);
        end
        cyc++;
        bclk_en = (cyc % div == 0);
        if (!run) slot = 0;
        if (bclk_en) begin
            fsync = fs_on && (slot % per == 0);
            slot++;
        end else fsync = 1'b0;
        in_valid = feed_en;
        in_data  = gen(m_seq);
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, WD_LIMIT);
            finish_up();
        end
    end

    task automatic scen(string req, logic [31:0] c, int p, bit feed, int ncyc);
        @(negedge clk); run = 0;
        repeat (8) @(negedge clk);
        cur_req = req; ctl = c; per = p; feed_en = feed; fs_on = 1;
        @(negedge clk); run = 1;
        repeat (ncyc) @(negedge clk);
    endtask

    initial begin
        // R1 / R9: reset state before release
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("reset sdo", sdo, 1'b0);
        chk("reset sync_err", sync_err, 1'b0);
        chk("reset underrun", underrun, 1'b0);
        cur_req = "R9";
        chk("reset in_ready", in_ready, 1'b1);
        rst_n = 1;
        // R1: stopped transmitter ignores frame syncs
        cur_req = "R1"; fs_on = 1; per = 10; feed_en = 1; ctl = mk(2, 1, 0, 0, 0, 0, 0);
        repeat (200) @(negedge clk);
        // R2: every size code, two words per frame, one-slot delay
        for (int code = 0; code < 8; code++)
            scen("R2", mk(code, 1, 0, 0, 0, 1, 0), 80, 1, 500);
        // R3: single phase, four 16-bit words
        scen("R3", mk(2, 3, 5, 9, 0, 1, 0), 80, 1, 700);
        // R4: dual phase, mixed sizes and counts
        scen("R4", mk(0, 2, 4, 0, 1, 1, 0), 60, 1, 700);
        scen("R4", mk(5, 0, 1, 1, 1, 1, 0), 64, 1, 700);
        // R5: zero delay, back-to-back frames and with a gap
        scen("R5", mk(2, 1, 0, 0, 0, 0, 0), 32, 1, 700);
        scen("R5", mk(3, 0, 0, 0, 0, 0, 0), 30, 1, 500);
        // R10: long gap between short frames
        scen("R10", mk(0, 0, 0, 0, 0, 1, 0), 40, 1, 500);
        // R6: early sync flagged and restarting, then ignored
        scen("R6", mk(2, 1, 0, 0, 0, 1, 0), 20, 1, 600);
        scen("R6", mk(2, 1, 0, 0, 0, 1, 1), 20, 1, 600);
        // R7: error from early syncs stays set after timing is corrected
        scen("R7", mk(2, 1, 0, 0, 0, 1, 0), 20, 1, 300);
        per = 80;
        repeat (600) @(negedge clk);
        run = 0;
        repeat (20) @(negedge clk);
        // R8: no words supplied, packed 32-bit pair repeats
        scen("R8", mk(5, 0, 0, 0, 0, 1, 0), 40, 1, 300);
        feed_en = 0;
        repeat (500) @(negedge clk);
        underrun_clr = 1; @(negedge clk); underrun_clr = 0;
        repeat (100) @(negedge clk);
        feed_en = 1;
        repeat (300) @(negedge clk);
        underrun_clr = 1; @(negedge clk); underrun_clr = 0;
        repeat (300) @(negedge clk);
        // R11 / R9: slower bit clock, source paced by handshake
        div = 3;
        scen("R11", mk(1, 2, 3, 1, 1, 1, 0), 90, 1, 1200);
        scen("R9", mk(4, 1, 0, 0, 0, 0, 0), 60, 1, 900);
        div = 2;
        finish_up();
    end
endmodule